// File: doc/BRIEF.md
# Multiprocessor Interrupt Routing Controller

This block collects device interrupt lines and software interrupts for a small multiprocessor of one to four CPUs. It gives each CPU a 4-bit interrupt level. Every register sits on a simple 32-bit register bus with an 8-bit byte address, a write strobe, write data and combinational read data.

Each CPU has its own window of three words. The first word is a readable pending view. The second is a write-one-to-clear port for software interrupts, and the third is a write-one-to-set port for software interrupts. A shared master section holds the following:
- a view of the device lines that are currently raised;
- a mask that is changed only through a clear port (which enables sources) and a set port (which disables sources);
- a global mask bit;
- a target register that names the single CPU to which unmasked device interrupts are steered.

Each device source has a fixed level. A CPU's level output is registered and shows the highest level among that CPU's pending software interrupts and the device interrupts routed to it.

Top module: `mp_irq_router`

## Requirements
- R1: Address map. CPU c's window starts at byte 16*c: pending view at +0, software clear port at +4, software set port at +8. The master section uses 0x40 for the device pending view, 0x44 for the mask, 0x48 for the mask clear port, 0x4C for the mask set port and 0x50 for the target. Windows of CPUs at or above NUM_CPUS do not respond.
- R2: A software set or clear write acts only on data bits written as 1, and only on bits 31:17. A bit written as 0, and any bit in 16:0, leaves the stored software state unchanged.
- R3: In a CPU's pending view, a software interrupt at level x reads at bit 16+x. A device interrupt routed to that CPU at level x reads at bit x. Bits 0 and 16 read 0.
- R4: Writing 1 to a bit of the mask clear port clears that mask bit, which enables the source. Writing 1 to a bit of the mask set port sets it, which disables the source. Direct writes to the mask address are ignored.
- R5: While mask bit 31 is set, no device interrupt reaches any CPU, whatever the other mask bits hold.
- R6: The device pending view at 0x40 shows each device input at its own bit while that input is high. Only the source bits read back. Source bits and their levels:
  - bits 28 to 30: level 15
  - bit 17: level 13
  - bits 14 and 15: level 12
  - bits 21 and 22: level 11
  - bit 19: level 10
  - bit 20: level 8
  - bit 16: level 6
  - bit 18: level 4
  - bits 7 to 13: levels 1 to 7 (bit b at level b-6)
- R7: An unmasked, pending device source goes only to the CPU named by the target register. The target reads back at 0x50. A write of a value at or above NUM_CPUS is ignored.
- R8: Each CPU level output equals the highest pending level on that CPU, or 0 when none is pending. It changes on the first clock edge after its inputs change.
- R9: After reset, every mask bit including bit 31 is set, all software interrupts are clear, the target is CPU 0 and all level outputs are 0.
- R10: Reads of the clear and set ports, and of unmapped addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| dev_irq_i | input | 32 | Device interrupt levels, one per source bit |
| cpu_level_o | output | 4*NUM_CPUS | Interrupt level per CPU, CPU c at bits 4c+3:4c |

## Verification
Software interrupts are posted on a single CPU at two levels. This shows that the highest level is chosen and that other CPUs stay untouched. Zero-data and low-half writes show that only written ones in the upper half act. Each device source is raised in turn with only its mask bit open, which pins each bit to its level. A non-source bit is raised to show it is dropped. A device interrupt is combined with software levels above and below it to check the priority merge. The target is moved to another CPU to tell the routing apart from a broadcast. The mask is exercised in four ways to separate the per-source mask from the global mask: clear-port writes, set-port writes, a direct write to the mask address, and the global bit set with the source bit open.

// File: rtl/mp_irq_pkg.sv
package mp_irq_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int LVL_W      = 4;
  localparam int CPU_STRIDE = 16;
  localparam int OFS_PEND   = 0;
  localparam int OFS_CLR    = 4;
  localparam int OFS_SET    = 8;
  localparam logic [ADDR_W-1:0] MST_PEND_A = 8'h40;
  localparam logic [ADDR_W-1:0] MST_MASK_A = 8'h44;
  localparam logic [ADDR_W-1:0] MST_CLR_A  = 8'h48;
  localparam logic [ADDR_W-1:0] MST_SET_A  = 8'h4C;
  localparam logic [ADDR_W-1:0] MST_TGT_A  = 8'h50;
  localparam int GLOBAL_BIT = 31;

  typedef logic [15:0] lvl_vec_t;

  // Fixed level of each device source bit; 0 marks a non-source bit.
  function automatic logic [LVL_W-1:0] src_level(input int b);
    if (b >= 7 && b <= 13) return LVL_W'(b - 6);
    case (b)
      14, 15:     return 4'd12;
      16:         return 4'd6;
      17:         return 4'd13;
      18:         return 4'd4;
      19:         return 4'd10;
      20:         return 4'd8;
      21, 22:     return 4'd11;
      28, 29, 30: return 4'd15;
      default:    return 4'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] src_valid_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++) m[b] = (src_level(b) != 4'd0);
    return m;
  endfunction

  localparam logic [DATA_W-1:0] SRC_VALID = src_valid_mask();

  function automatic logic [LVL_W-1:0] top_level(input lvl_vec_t v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < 16; i++) if (v[i]) r = LVL_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/mp_irq_cpu_regs.sv
module mp_irq_cpu_regs
  import mp_irq_pkg::*;
#(
  parameter int CPU_IDX = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [15:0]         wdata_hi_i,
  output lvl_vec_t            soft_o
);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CPU_IDX * CPU_STRIDE + OFS_CLR);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(CPU_IDX * CPU_STRIDE + OFS_SET);

  lvl_vec_t soft_q, clr_bits, set_bits;

  assign clr_bits = (reg_wr_i && reg_addr_i == CLR_A) ? wdata_hi_i : '0;
  assign set_bits = (reg_wr_i && reg_addr_i == SET_A) ? wdata_hi_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_q <= '0;
    else         soft_q <= ((soft_q & ~clr_bits) | set_bits) & 16'hFFFE;
  end

  assign soft_o = soft_q;
endmodule

// File: rtl/mp_irq_master.sv
module mp_irq_master
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int TGT_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_wr_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [DATA_W-1:0]             reg_wdata_i,
  input  logic [DATA_W-1:0]             dev_irq_i,
  output logic [DATA_W-1:0]             pend_o,
  output logic [DATA_W-1:0]             mask_o,
  output logic [TGT_W-1:0]              target_o,
  output lvl_vec_t [NUM_CPUS-1:0]       hard_o
);
  logic [DATA_W-1:0] mask_q, eff;
  logic [TGT_W-1:0]  target_q;
  lvl_vec_t          routed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '1;
      target_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == MST_CLR_A) mask_q <= mask_q & ~reg_wdata_i;
      if (reg_addr_i == MST_SET_A) mask_q <= mask_q | reg_wdata_i;
      if (reg_addr_i == MST_TGT_A && reg_wdata_i < DATA_W'(NUM_CPUS))
        target_q <= reg_wdata_i[TGT_W-1:0];
    end
  end

  assign pend_o = dev_irq_i & SRC_VALID;
  assign eff    = mask_q[GLOBAL_BIT] ? '0 : (pend_o & ~mask_q);

  always_comb begin
    routed = '0;
    for (int b = 0; b < DATA_W; b++)
      if (eff[b]) routed[src_level(b)] = 1'b1;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_route
    assign hard_o[c] = (target_q == TGT_W'(c)) ? routed : '0;
  end

  assign mask_o   = mask_q;
  assign target_o = target_q;
endmodule

// File: rtl/mp_irq_lvl_enc.sv
module mp_irq_lvl_enc
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  lvl_vec_t [NUM_CPUS-1:0]       soft_i,
  input  lvl_vec_t [NUM_CPUS-1:0]       hard_i,
  output logic [LVL_W*NUM_CPUS-1:0]     level_o
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= '0;
      else         lvl_q <= top_level(soft_i[c] | hard_i[c]);
    end
    assign level_o[LVL_W*c +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/mp_irq_router.sv
module mp_irq_router
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 reg_addr_i,
  input  logic                       reg_wr_i,
  input  logic [31:0]                reg_wdata_i,
  output logic [31:0]                reg_rdata_o,
  input  logic [31:0]                dev_irq_i,
  output logic [4*NUM_CPUS-1:0]      cpu_level_o
);
  localparam int TGT_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

  lvl_vec_t [NUM_CPUS-1:0] soft_w, hard_w;
  logic [DATA_W-1:0]       pend_w, mask_w;
  logic [TGT_W-1:0]        target_w;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    mp_irq_cpu_regs #(.CPU_IDX(c)) cpu_regs_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .reg_wr_i   (reg_wr_i),
      .reg_addr_i (reg_addr_i),
      .wdata_hi_i (reg_wdata_i[31:16]),
      .soft_o     (soft_w[c])
    );
  end

  mp_irq_master #(.NUM_CPUS(NUM_CPUS), .TGT_W(TGT_W)) master_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .dev_irq_i   (dev_irq_i),
    .pend_o      (pend_w),
    .mask_o      (mask_w),
    .target_o    (target_w),
    .hard_o      (hard_w)
  );

  mp_irq_lvl_enc #(.NUM_CPUS(NUM_CPUS)) lvl_enc_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .soft_i  (soft_w),
    .hard_i  (hard_w),
    .level_o (cpu_level_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      if (reg_addr_i == ADDR_W'(c * CPU_STRIDE + OFS_PEND))
        reg_rdata_o = {soft_w[c], hard_w[c]};
    if (reg_addr_i == MST_PEND_A) reg_rdata_o = pend_w;
    if (reg_addr_i == MST_MASK_A) reg_rdata_o = mask_w;
    if (reg_addr_i == MST_TGT_A)  reg_rdata_o = DATA_W'(target_w);
  end
endmodule

// File: rtl/mp_irq_router_chk.sv
module mp_irq_router_chk
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int TGT_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [7:0]               reg_addr_i,
  input logic                     reg_wr_i,
  input logic [31:0]              reg_wdata_i,
  input logic [31:0]              reg_rdata_o,
  input logic [4*NUM_CPUS-1:0]    cpu_level_o,
  input logic [31:0]              mask_q_i,
  input logic [TGT_W-1:0]         target_q_i,
  input lvl_vec_t [NUM_CPUS-1:0]  soft_q_i
);
  assert_mask_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == MST_SET_A) |=> ((mask_q_i & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  assert_mask_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == MST_CLR_A) |=> ((mask_q_i & $past(reg_wdata_i)) == 32'd0));

  assert_target_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(target_q_i) < NUM_CPUS);

  assert_target_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == MST_TGT_A) |=> $stable(target_q_i));

  assert_wo_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == MST_CLR_A || reg_addr_i == MST_SET_A) |-> reg_rdata_o == 32'd0);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assert_soft_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_addr_i == 8'(c * CPU_STRIDE + OFS_CLR))
      |=> ((soft_q_i[c] & $past(reg_wdata_i[31:16])) == 16'd0));

    assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (soft_q_i[c] == 16'd0 && (mask_q_i[GLOBAL_BIT] || target_q_i != TGT_W'(c)))
      |=> cpu_level_o[4*c +: 4] == 4'd0);
  end
endmodule

bind mp_irq_router mp_irq_router_chk #(.NUM_CPUS(NUM_CPUS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .cpu_level_o (cpu_level_o),
  .mask_q_i    (mask_w),
  .target_q_i  (target_w),
  .soft_q_i    (soft_w)
);

// File: tb/mp_irq_router_tb_top.sv
module mp_irq_router_tb_top;
  localparam int NC = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [7:0]      reg_addr_i = '0;
  logic            reg_wr_i = 1'b0;
  logic [31:0]     reg_wdata_i = '0;
  logic [31:0]     reg_rdata_o;
  logic [31:0]     dev_irq_i = '0;
  logic [4*NC-1:0] cpu_level_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mp_irq_router #(.NUM_CPUS(NC)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .dev_irq_i   (dev_irq_i),
    .cpu_level_o (cpu_level_o)
  );

  // Source levels as listed in R6.
  function automatic int exp_level(input int b);
    if (b >= 7 && b <= 13) return b - 6;
    case (b)
      14, 15: return 12;
      16: return 6;
      17: return 13;
      18: return 4;
      19: return 10;
      20: return 8;
      21, 22: return 11;
      28, 29, 30: return 15;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic settle();
    @(negedge clk_i);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic lvl_chk(input string req, input int l0, input int l1, input int l2, input int l3);
    chk(req, 32'(cpu_level_o), {16'd0, 4'(l3), 4'(l2), 4'(l1), 4'(l0)});
  endtask

  task automatic t_reset();
    lvl_chk("R9 levels", 0, 0, 0, 0);
    rd_chk("R9 mask", 8'h44, 32'hFFFF_FFFF);
    rd_chk("R9 target", 8'h50, 32'd0);
    for (int c = 0; c < NC; c++) rd_chk("R9 cpu pending", 8'(c * 16), 32'd0);
  endtask

  task automatic t_soft();
    wr(8'h18, 32'd1 << 21); settle();
    lvl_chk("R8 soft level 5 on cpu1 only", 0, 5, 0, 0);
    rd_chk("R3 soft bit layout", 8'h10, 32'd1 << 21);
    wr(8'h18, 32'd1 << 25); settle();
    lvl_chk("R8 highest soft level", 0, 9, 0, 0);
    wr(8'h18, 32'd0); settle();
    lvl_chk("R2 zero set write", 0, 9, 0, 0);
    wr(8'h14, 32'd1 << 25); settle();
    lvl_chk("R2 clear one bit", 0, 5, 0, 0);
    rd_chk("R2 other bit kept", 8'h10, 32'd1 << 21);
    wr(8'h18, 32'h0001_FFFF); settle();
    rd_chk("R2 low half ignored", 8'h10, 32'd1 << 21);
    wr(8'h14, 32'd1 << 21); settle();
    lvl_chk("R2 cleared", 0, 0, 0, 0);
  endtask

  task automatic t_wo_reads();
    wr(8'h08, 32'd1 << 20); settle();
    rd_chk("R10 clr port read", 8'h04, 32'd0);
    rd_chk("R10 set port read", 8'h08, 32'd0);
    rd_chk("R10 mask clr read", 8'h48, 32'd0);
    rd_chk("R10 mask set read", 8'h4C, 32'd0);
    rd_chk("R10 unmapped read", 8'h60, 32'd0);
    rd_chk("R1 cpu0 window", 8'h00, 32'd1 << 20);
    wr(8'h04, 32'd1 << 20); settle();
  endtask

  task automatic t_device();
    dev_irq_i = 32'd1 << 19; settle();
    rd_chk("R6 device pending", 8'h40, 32'd1 << 19);
    lvl_chk("R9 masked at reset", 0, 0, 0, 0);
    wr(8'h48, 32'd1 << 19); settle();
    lvl_chk("R5 global mask blocks", 0, 0, 0, 0);
    rd_chk("R4 clear port", 8'h44, 32'hFFF7_FFFF);
    wr(8'h48, 32'h8000_0000); settle();
    lvl_chk("R7 routed to cpu0", 10, 0, 0, 0);
    rd_chk("R3 hard bit layout", 8'h00, 32'd1 << 10);
    rd_chk("R4 mask after clears", 8'h44, 32'h7FF7_FFFF);
  endtask

  task automatic t_target();
    wr(8'h50, 32'd2); settle();
    lvl_chk("R7 moved to cpu2", 0, 0, 10, 0);
    rd_chk("R7 target read", 8'h50, 32'd2);
    wr(8'h50, 32'd7); settle();
    rd_chk("R7 out of range ignored", 8'h50, 32'd2);
    lvl_chk("R7 still cpu2", 0, 0, 10, 0);
  endtask

  task automatic t_mask_direct();
    wr(8'h44, 32'd0); settle();
    rd_chk("R4 direct write ignored", 8'h44, 32'h7FF7_FFFF);
  endtask

  task automatic t_prio();
    wr(8'h28, 32'd1 << 19); settle();
    lvl_chk("R8 device over soft", 0, 0, 10, 0);
    wr(8'h28, 32'd1 << 31); settle();
    lvl_chk("R8 soft over device", 0, 0, 15, 0);
    wr(8'h24, 32'h8008_0000); settle();
    lvl_chk("R8 back to device", 0, 0, 10, 0);
  endtask

  task automatic t_sources();
    int srcs [0:18] = '{7, 8, 9, 10, 11, 12, 13, 14, 15, 16, 17, 18, 20, 21, 22, 28, 29, 30, 19};
    wr(8'h4C, 32'd1 << 19);
    for (int i = 0; i < 19; i++) begin
      dev_irq_i = 32'd1 << srcs[i];
      wr(8'h48, 32'd1 << srcs[i]); settle();
      lvl_chk("R6 source level", 0, 0, exp_level(srcs[i]), 0);
      if (srcs[i] != 19) wr(8'h4C, 32'd1 << srcs[i]);
    end
    dev_irq_i = 32'd1 << 25;
    wr(8'h48, 32'd1 << 25); settle();
    rd_chk("R6 non-source bit", 8'h40, 32'd0);
    lvl_chk("R6 non-source no level", 0, 0, 0, 0);
    wr(8'h4C, 32'd1 << 25);
  endtask

  task automatic t_global();
    dev_irq_i = 32'd1 << 19; settle();
    lvl_chk("R7 restore", 0, 0, 10, 0);
    wr(8'h4C, 32'h8000_0000); settle();
    lvl_chk("R5 global set blocks", 0, 0, 0, 0);
    rd_chk("R5 hard view blocked", 8'h20, 32'd0);
    wr(8'h4C, 32'd1 << 19);
    wr(8'h48, 32'h8000_0000); settle();
    lvl_chk("R4 set port disables", 0, 0, 0, 0);
    dev_irq_i = '0; settle();
    rd_chk("R6 line low", 8'h40, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    t_reset();
    t_soft();
    t_wo_reads();
    t_device();
    t_target();
    t_mask_direct();
    t_prio();
    t_sources();
    t_global();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule